// File: doc/BRIEF.md
# Scan Instruction Register and Data Path Selector

This block is the instruction side of a boundary-scan test port. It holds a serial instruction shift stage and a parallel shadow copy of the active instruction. It also holds a one-bit pass-through register and an optional 32-bit identity register. The port controller drives capture, shift and update strobes and an asynchronous reset. The block answers with the serial output of whichever path is active. When the controller flags an instruction scan, that path is the instruction stage. Otherwise it is the data register that the active instruction picks.

The latched instruction is decoded into a data register choice (pass-through, boundary chain or identity) and a pin mode for the boundary cells: functional, external test, internal test, clamp or outputs disabled. The boundary chain itself sits outside the block. Only its serial output comes back in, so that it can be routed to the test output.

Top module: `scan_ir_select`

## Requirements
- R1: On an instruction capture strobe, the instruction shift stage loads the value 1: bit 0 = 1, bit 1 = 0, and every higher bit 0.
- R2: On an instruction shift strobe, the stage moves one place toward bit 0 and takes `tdi_i` into its top bit. While `ir_path_i` is high, `tdo_o` shows stage bit 0.
- R3: `ir_q_o` keeps its value through instruction capture and shift. It takes the shift stage contents only on an instruction update strobe.
- R4: Reset sets the shift stage and `ir_q_o` to all ones. When the identity register is present, `dr_sel_o` is 2 (identity) with `mode_o` 0 until the first instruction update. Otherwise it is 0 (pass-through).
- R5: The all-ones instruction gives `dr_sel_o` = 0 and `mode_o` = 0 (functional). The pass-through bit loads 0 on a data capture and takes `tdi_i` on a data shift, so data comes out one shift late.
- R6: The all-zeros instruction gives `dr_sel_o` = 1 (boundary chain) and `mode_o` = 1 (external test).
- R7: The sample opcode (default 1) gives `dr_sel_o` = 1 with `mode_o` = 0. The internal-test opcode (default 2) gives `dr_sel_o` = 1 with `mode_o` = 2.
- R8: The clamp opcode (default 3) gives `dr_sel_o` = 0 with `mode_o` = 3: the pins hold the chain's values while the pass-through bit is in the serial path.
- R9: The disable opcode (default 4) gives `dr_sel_o` = 0 with `mode_o` = 4: all three-state outputs are off.
- R10: The identity opcode (default 5) gives `dr_sel_o` = 2. A data capture loads `ID_VALUE`, whose bit 0 is 1 and whose bits 11..1 hold the maker code. The register shifts out bit 0 first over 32 shifts.
- R11: During a data capture or shift, a data register that is not selected keeps its contents.
- R12: Any opcode that is not assigned decodes like the all-ones instruction: pass-through, functional.
- R13: While `ir_path_i` is low, `tdo_o` shows bit 0 of the selected data register. When the boundary chain is selected, it shows `bsr_so_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous test logic reset, active low |
| tdi_i | input | 1 | Serial test data in |
| ir_path_i | input | 1 | High while the instruction path is being scanned |
| ir_capture_i | input | 1 | Instruction capture strobe |
| ir_shift_i | input | 1 | Instruction shift strobe |
| ir_update_i | input | 1 | Instruction update strobe |
| dr_capture_i | input | 1 | Data register capture strobe |
| dr_shift_i | input | 1 | Data register shift strobe |
| bsr_so_i | input | 1 | Serial output of the external boundary chain |
| tdo_o | output | 1 | Serial output of the active path |
| ir_q_o | output | IR_W | Latched instruction |
| dr_sel_o | output | 2 | Data register choice: 0 pass-through, 1 boundary, 2 identity |
| mode_o | output | 3 | Pin mode: 0 functional, 1 external, 2 internal, 3 clamp, 4 outputs off |

## Verification
Several properties are checked on every cycle: the shadow copy stays stable except after an update, and the all-ones, all-zeros, clamp and disable opcodes map to their path and pin mode. The same checks cover the boundary chain being routed to `tdo_o` and the pass-through bit reading 0 after a capture. Other behaviour only the directed scenarios can show. These cover the capture pattern shifted out of the instruction stage, the identity value read bit by bit, and the choice of the identity register after reset and after a second reset mid-run. They also cover the identity register holding a scanned-in pattern while pass-through scans run.

// File: rtl/scan_ir_pkg.sv
package scan_ir_pkg;

   typedef enum logic [1:0] {
      DR_PASS     = 2'd0,
      DR_BOUNDARY = 2'd1,
      DR_IDENT    = 2'd2
   } dr_sel_e;

   typedef enum logic [2:0] {
      PIN_FUNC   = 3'd0,
      PIN_EXT    = 3'd1,
      PIN_INT    = 3'd2,
      PIN_CLAMP  = 3'd3,
      PIN_OFF    = 3'd4
   } pin_mode_e;

   localparam int unsigned ID_W = 32;

endpackage

// File: rtl/scan_ir_reg.sv
module scan_ir_reg #(
   parameter int unsigned IR_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tdi_i,
   input  logic            capture_i,
   input  logic            shift_i,
   input  logic            update_i,
   output logic            sr_lsb_o,
   output logic [IR_W-1:0] instr_o,
   output logic            fresh_o
);
   // status pattern: 01 in the two low bits, zeros above
   localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

   logic [IR_W-1:0] sr_q;
   logic [IR_W-1:0] sh_q;
   logic            fresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '1;
      end else if (capture_i) begin
         sr_q <= CAP_PAT;
      end else if (shift_i) begin
         sr_q <= {tdi_i, sr_q[IR_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '1;
         fresh_q <= 1'b1;
      end else if (update_i) begin
         sh_q    <= sr_q;
         fresh_q <= 1'b0;
      end
   end

   assign sr_lsb_o = sr_q[0];
   assign instr_o  = sh_q;
   assign fresh_o  = fresh_q;

endmodule

// File: rtl/scan_ir_decode.sv
module scan_ir_decode
   import scan_ir_pkg::*;
#(
   parameter int unsigned IR_W      = 4,
   parameter bit          HAS_ID    = 1'b1,
   parameter int unsigned OP_SAMPLE = 1,
   parameter int unsigned OP_INTEST = 2,
   parameter int unsigned OP_CLAMP  = 3,
   parameter int unsigned OP_HIGHZ  = 4,
   parameter int unsigned OP_IDCODE = 5
) (
   input  logic [IR_W-1:0] instr_i,
   input  logic            fresh_i,
   output dr_sel_e         dr_sel_o,
   output pin_mode_e       mode_o
);
   localparam logic [IR_W-1:0] C_EXT    = '0;
   localparam logic [IR_W-1:0] C_SAMPLE = IR_W'(OP_SAMPLE);
   localparam logic [IR_W-1:0] C_INTEST = IR_W'(OP_INTEST);
   localparam logic [IR_W-1:0] C_CLAMP  = IR_W'(OP_CLAMP);
   localparam logic [IR_W-1:0] C_HIGHZ  = IR_W'(OP_HIGHZ);
   localparam logic [IR_W-1:0] C_IDCODE = IR_W'(OP_IDCODE);

   always_comb begin
      dr_sel_o = DR_PASS;
      mode_o   = PIN_FUNC;
      if (fresh_i && HAS_ID) begin
         dr_sel_o = DR_IDENT;
      end else if (instr_i == C_EXT) begin
         dr_sel_o = DR_BOUNDARY;
         mode_o   = PIN_EXT;
      end else if (instr_i == C_SAMPLE) begin
         dr_sel_o = DR_BOUNDARY;
      end else if (instr_i == C_INTEST) begin
         dr_sel_o = DR_BOUNDARY;
         mode_o   = PIN_INT;
      end else if (instr_i == C_CLAMP) begin
         mode_o   = PIN_CLAMP;
      end else if (instr_i == C_HIGHZ) begin
         mode_o   = PIN_OFF;
      end else if (instr_i == C_IDCODE && HAS_ID) begin
         dr_sel_o = DR_IDENT;
      end
   end

endmodule

// File: rtl/scan_dr_bank.sv
module scan_dr_bank
   import scan_ir_pkg::*;
#(
   parameter bit              HAS_ID   = 1'b1,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_E0F3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tdi_i,
   input  logic    capture_i,
   input  logic    shift_i,
   input  dr_sel_e sel_i,
   output logic    pass_so_o,
   output logic    id_so_o
);
   logic pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_q <= 1'b0;
      end else if (sel_i == DR_PASS) begin
         if (capture_i)    pass_q <= 1'b0;
         else if (shift_i) pass_q <= tdi_i;
      end
   end
   assign pass_so_o = pass_q;

   generate
      if (HAS_ID) begin : g_id
         logic [ID_W-1:0] id_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_q <= ID_VALUE;
            end else if (sel_i == DR_IDENT) begin
               if (capture_i)    id_q <= ID_VALUE;
               else if (shift_i) id_q <= {tdi_i, id_q[ID_W-1:1]};
            end
         end
         assign id_so_o = id_q[0];
      end else begin : g_no_id
         assign id_so_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/scan_ir_select.sv
module scan_ir_select
   import scan_ir_pkg::*;
#(
   parameter int unsigned     IR_W      = 4,
   parameter bit              HAS_ID    = 1'b1,
   parameter logic [ID_W-1:0] ID_VALUE  = 32'h1A5C_E0F3,
   parameter int unsigned     OP_SAMPLE = 1,
   parameter int unsigned     OP_INTEST = 2,
   parameter int unsigned     OP_CLAMP  = 3,
   parameter int unsigned     OP_HIGHZ  = 4,
   parameter int unsigned     OP_IDCODE = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tdi_i,
   input  logic            ir_path_i,
   input  logic            ir_capture_i,
   input  logic            ir_shift_i,
   input  logic            ir_update_i,
   input  logic            dr_capture_i,
   input  logic            dr_shift_i,
   input  logic            bsr_so_i,
   output logic            tdo_o,
   output logic [IR_W-1:0] ir_q_o,
   output logic [1:0]      dr_sel_o,
   output logic [2:0]      mode_o
);
   localparam int unsigned OP_MAX = (1 << IR_W) - 2;

   // elaboration-time parameter checks
   generate
      if (IR_W < 2 || IR_W > 16) begin : g_bad_width
         $error("IR_W must lie in 2..16");
      end
      if (OP_SAMPLE == 0 || OP_SAMPLE > OP_MAX || OP_INTEST == 0 || OP_INTEST > OP_MAX ||
          OP_CLAMP  == 0 || OP_CLAMP  > OP_MAX || OP_HIGHZ  == 0 || OP_HIGHZ  > OP_MAX ||
          OP_IDCODE == 0 || OP_IDCODE > OP_MAX) begin : g_bad_op
         $error("opcodes must differ from all-zeros and all-ones and fit IR_W");
      end
      if (OP_SAMPLE == OP_INTEST || OP_SAMPLE == OP_CLAMP || OP_SAMPLE == OP_HIGHZ ||
          OP_SAMPLE == OP_IDCODE || OP_INTEST == OP_CLAMP || OP_INTEST == OP_HIGHZ ||
          OP_INTEST == OP_IDCODE || OP_CLAMP  == OP_HIGHZ || OP_CLAMP  == OP_IDCODE ||
          OP_HIGHZ  == OP_IDCODE) begin : g_dup_op
         $error("opcodes must be distinct");
      end
      if (HAS_ID && ID_VALUE[0] != 1'b1) begin : g_bad_id
         $error("identity value bit 0 must be 1");
      end
   endgenerate

   logic      ir_lsb;
   logic      fresh;
   logic      pass_so;
   logic      id_so;
   dr_sel_e   dr_sel;
   pin_mode_e mode;

   scan_ir_reg #(.IR_W(IR_W)) u_ir (
      .clk       (clk),
      .rst_n     (rst_n),
      .tdi_i     (tdi_i),
      .capture_i (ir_capture_i),
      .shift_i   (ir_shift_i),
      .update_i  (ir_update_i),
      .sr_lsb_o  (ir_lsb),
      .instr_o   (ir_q_o),
      .fresh_o   (fresh)
   );

   scan_ir_decode #(
      .IR_W      (IR_W),
      .HAS_ID    (HAS_ID),
      .OP_SAMPLE (OP_SAMPLE),
      .OP_INTEST (OP_INTEST),
      .OP_CLAMP  (OP_CLAMP),
      .OP_HIGHZ  (OP_HIGHZ),
      .OP_IDCODE (OP_IDCODE)
   ) u_dec (
      .instr_i  (ir_q_o),
      .fresh_i  (fresh),
      .dr_sel_o (dr_sel),
      .mode_o   (mode)
   );

   scan_dr_bank #(.HAS_ID(HAS_ID), .ID_VALUE(ID_VALUE)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .tdi_i     (tdi_i),
      .capture_i (dr_capture_i),
      .shift_i   (dr_shift_i),
      .sel_i     (dr_sel),
      .pass_so_o (pass_so),
      .id_so_o   (id_so)
   );

   always_comb begin
      if (ir_path_i) begin
         tdo_o = ir_lsb;
      end else begin
         unique case (dr_sel)
            DR_BOUNDARY: tdo_o = bsr_so_i;
            DR_IDENT:    tdo_o = id_so;
            default:     tdo_o = pass_so;
         endcase
      end
   end

   assign dr_sel_o = dr_sel;
   assign mode_o   = mode;

endmodule

// File: rtl/scan_ir_select_chk.sv
module scan_ir_select_chk #(
   parameter int unsigned IR_W     = 4,
   parameter int unsigned OP_CLAMP = 3,
   parameter int unsigned OP_HIGHZ = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ir_path_i,
   input logic            ir_update_i,
   input logic            dr_capture_i,
   input logic            bsr_so_i,
   input logic            tdo_o,
   input logic [IR_W-1:0] ir_q_o,
   input logic [1:0]      dr_sel_o,
   input logic [2:0]      mode_o
);
   assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ir_update_i) |-> $stable(ir_q_o));

   assert_ones_functional_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q_o == '1) |-> (dr_sel_o != 2'd1 && mode_o == 3'd0));

   assert_pass_capture_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dr_capture_i) && $past(dr_sel_o) == 2'd0 && dr_sel_o == 2'd0 && !ir_path_i)
      |-> (tdo_o == 1'b0));

   assert_zeros_external_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q_o == '0) |-> (dr_sel_o == 2'd1 && mode_o == 3'd1));

   assert_clamp_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q_o == IR_W'(OP_CLAMP)) |-> (dr_sel_o == 2'd0 && mode_o == 3'd3));

   assert_highz_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q_o == IR_W'(OP_HIGHZ)) |-> (dr_sel_o == 2'd0 && mode_o == 3'd4));

   assert_chain_route_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_path_i && dr_sel_o == 2'd1) |-> (tdo_o == bsr_so_i));

endmodule

bind scan_ir_select scan_ir_select_chk #(
   .IR_W     (IR_W),
   .OP_CLAMP (OP_CLAMP),
   .OP_HIGHZ (OP_HIGHZ)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ir_path_i    (ir_path_i),
   .ir_update_i  (ir_update_i),
   .dr_capture_i (dr_capture_i),
   .bsr_so_i     (bsr_so_i),
   .tdo_o        (tdo_o),
   .ir_q_o       (ir_q_o),
   .dr_sel_o     (dr_sel_o),
   .mode_o       (mode_o)
);

// File: tb/scan_ir_select_tb_top.sv
module scan_ir_select_tb_top;
   localparam int unsigned IR_W  = 4;
   localparam logic [31:0] IDV   = 32'h1A5C_E0F3;
   localparam logic [31:0] PAT   = 32'hC3A5_0F69;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tdi = 1'b0, ir_path = 1'b0, ir_cap = 1'b0, ir_sh = 1'b0, ir_up = 1'b0;
   logic dr_cap = 1'b0, dr_sh = 1'b0, bsr_so = 1'b0;
   logic tdo;
   logic [IR_W-1:0] ir_q;
   logic [1:0] dr_sel;
   logic [2:0] mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   scan_ir_select #(.IR_W(IR_W), .ID_VALUE(IDV)) dut_i (
      .clk(clk), .rst_n(rst_n), .tdi_i(tdi), .ir_path_i(ir_path),
      .ir_capture_i(ir_cap), .ir_shift_i(ir_sh), .ir_update_i(ir_up),
      .dr_capture_i(dr_cap), .dr_shift_i(dr_sh), .bsr_so_i(bsr_so),
      .tdo_o(tdo), .ir_q_o(ir_q), .dr_sel_o(dr_sel), .mode_o(mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock with the given strobes, sampled 1 ns after the edge
   task automatic strobe(input logic c_ir, s_ir, u_ir, c_dr, s_dr, d);
      @(negedge clk);
      ir_cap = c_ir; ir_sh = s_ir; ir_up = u_ir; dr_cap = c_dr; dr_sh = s_dr; tdi = d;
      @(posedge clk);
      #1;
      ir_cap = 0; ir_sh = 0; ir_up = 0; dr_cap = 0; dr_sh = 0; tdi = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic load_ir(input logic [IR_W-1:0] op);
      logic [IR_W-1:0] prev;
      logic [IR_W-1:0] cap;
      prev = ir_q;
      ir_path = 1'b1;
      strobe(1, 0, 0, 0, 0, 0);
      check("R3 shadow after capture", 32'(ir_q), 32'(prev));
      for (int i = 0; i < IR_W; i++) begin
         cap[i] = tdo;
         strobe(0, 1, 0, 0, 0, op[i]);
      end
      check("R1 captured pattern", 32'(cap), 32'(1));
      check("R3 shadow after shift", 32'(ir_q), 32'(prev));
      strobe(0, 0, 1, 0, 0, 0);
      check("R2 shifted opcode latched", 32'(ir_q), 32'(op));
      ir_path = 1'b0;
      #1;
   endtask

   task automatic read_dr(input bit do_cap, input logic [31:0] din, output logic [31:0] val);
      if (do_cap) strobe(0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 32; i++) begin
         val[i] = tdo;
         strobe(0, 0, 0, 0, 1, din[i]);
      end
   endtask

   task automatic t_reset();
      do_reset();
      check("R4 ir after reset", 32'(ir_q), 32'hF);
      check("R4 identity selected", 32'(dr_sel), 32'd2);
      check("R4 functional", 32'(mode), 32'd0);
      check("R13 tdo shows id bit0", 32'(tdo), 32'd1);
   endtask

   task automatic t_id_read();
      logic [31:0] v;
      read_dr(1'b1, PAT, v);
      check("R10 identity value", v, IDV);
      check("R10 bit0 is one", 32'(v[0]), 32'd1);
   endtask

   task automatic t_unassigned();
      load_ir(4'b1010);
      check("R12 path", 32'(dr_sel), 32'd0);
      check("R12 mode", 32'(mode), 32'd0);
   endtask

   task automatic t_pass_and_hold();
      logic [31:0] v;
      logic [3:0] bits = 4'b1101;
      strobe(0, 0, 0, 1, 0, 0);
      check("R5 pass captures 0", 32'(tdo), 32'd0);
      for (int i = 0; i < 4; i++) begin
         strobe(0, 0, 0, 0, 1, bits[i]);
         check("R5 pass delay", 32'(tdo), 32'(bits[i]));
      end
      load_ir(4'(5));
      check("R10 identity path", 32'(dr_sel), 32'd2);
      read_dr(1'b0, 32'h0, v);
      check("R11 identity held", v, PAT);
   endtask

   task automatic t_modes();
      load_ir(4'b0000);
      check("R6 path", 32'(dr_sel), 32'd1);
      check("R6 mode", 32'(mode), 32'd1);
      bsr_so = 1'b1; #1;
      check("R13 chain one", 32'(tdo), 32'd1);
      bsr_so = 1'b0; #1;
      check("R13 chain zero", 32'(tdo), 32'd0);
      load_ir(4'(1));
      check("R7 sample", {dr_sel, mode}, {27'd0, 2'd1, 3'd0});
      load_ir(4'(2));
      check("R7 internal", {dr_sel, mode}, {27'd0, 2'd1, 3'd2});
      load_ir(4'(3));
      check("R8 clamp", {dr_sel, mode}, {27'd0, 2'd0, 3'd3});
      load_ir(4'(4));
      check("R9 off", {dr_sel, mode}, {27'd0, 2'd0, 3'd4});
      load_ir(4'hF);
      check("R5 all ones", {dr_sel, mode}, {27'd0, 2'd0, 3'd0});
   endtask

   task automatic t_reset_again();
      load_ir(4'b0000);
      do_reset();
      check("R4 ir after second reset", 32'(ir_q), 32'hF);
      check("R4 identity again", 32'(dr_sel), 32'd2);
      ir_path = 1'b1; #1;
      check("R2 ir lsb out", 32'(tdo), 32'd1);
      ir_path = 1'b0;
   endtask

   initial begin
      t_reset();
      t_id_read();
      t_unassigned();
      t_pass_and_hold();
      t_modes();
      t_reset_again();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule